// File: doc/BRIEF.md
# Coherent Master Port Sequencer

This block is the cache-side endpoint of a coherent link made of seven valid/ready streams, arranged as a read group (command, response, acknowledge), a write group (command, response) and a probe group (command, response). Local fill and upgrade requests leave as read commands. Each read response updates a small per-line state table that stands in for the cache, and is always answered by exactly one read acknowledge. Local evictions become write commands, either a writeback of a dirty line or a notice that a clean line was dropped. Probes from the interconnect downgrade or invalidate lines.

Deadlock is avoided by a fixed stream ranking. The response-type streams, meaning write command, write response, read response, read acknowledge and probe response, never wait on probe commands or read commands. A probe is held back only while writes the port has issued are still waiting for their responses. Only one read may be in flight per line, and a second request to that line waits until the first read's acknowledge has left the port.

Line state is four bits, {valid, unique, owner, dirty}, with valid as the most significant bit. A dirty line is always also the owner.

Top module: `coh_master_port`

## Requirements
- R1: After reset every line reads 4'b0000 on the lookup port, no output stream is valid, and `req_ready` is high.
- R2: An accepted request appears on the read command stream on the next cycle with the same op (0 shared, 1 unique, 2 once, 3 make-unique) and line. It is held stable until `rc_ready`.
- R3: While a line has a read in flight, meaning its command was accepted and its acknowledge has not yet been taken, a new request to that line sees `req_ready` low. Requests to other lines are still accepted.
- R4: Every accepted read response yields exactly one read acknowledge on the next cycle, carrying the response's line. `rr_ready` is low only while an earlier acknowledge waits on `ra_ready`.
- R5: A data response (kind 2) for a shared or unique read stores `rr_state` into the line. A data response for a read-once leaves the line unchanged.
- R6: An error response (kind 1) leaves the line at 4'b0000.
- R7: A success response (kind 0) to make-unique sets valid and unique and keeps owner and dirty.
- R8: Evicting a valid line emits one write command on the next cycle. Its kind is 1 (writeback) if the line was dirty and 0 (notice) otherwise, and the line becomes 4'b0000. Evicting an invalid line emits nothing.
- R9: `pc_ready` is low while any emitted write command lacks its write response. `ev_ready` is low while MAX_WR writes are outstanding.
- R10: An accepted probe yields one probe response on the next cycle. Kind 1 leaves the line at 4'b0000; kind 0 clears only the unique bit.
- R11: No stored line is ever dirty without being owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Local read request valid |
| req_ready | output | 1 | Local read request accepted |
| req_op | input | 2 | 0 shared, 1 unique, 2 once, 3 make-unique |
| req_addr | input | AW | Line index of the request |
| ev_valid | input | 1 | Local eviction valid |
| ev_ready | output | 1 | Eviction accepted |
| ev_addr | input | AW | Line to evict |
| lk_addr | input | AW | Lookup line index |
| lk_state | output | 4 | Stored state {valid, unique, owner, dirty} |
| rc_valid | output | 1 | Read command valid |
| rc_ready | input | 1 | Read command taken |
| rc_op | output | 2 | Read command op |
| rc_addr | output | AW | Read command line |
| rr_valid | input | 1 | Read response valid |
| rr_ready | output | 1 | Read response accepted |
| rr_kind | input | 2 | 0 success, 1 error, 2 data |
| rr_addr | input | AW | Read response line |
| rr_state | input | 4 | Returned line state for data responses |
| ra_valid | output | 1 | Read acknowledge valid |
| ra_ready | input | 1 | Read acknowledge taken |
| ra_addr | output | AW | Acknowledged line |
| wc_valid | output | 1 | Write command valid |
| wc_ready | input | 1 | Write command taken |
| wc_kind | output | 1 | 1 writeback, 0 eviction notice |
| wc_addr | output | AW | Write command line |
| wr_valid | input | 1 | Write response valid |
| wr_ready | output | 1 | Write response accepted, always high |
| pc_valid | input | 1 | Probe command valid |
| pc_ready | output | 1 | Probe command accepted |
| pc_kind | input | 1 | 0 make shared, 1 invalidate |
| pc_addr | input | AW | Probed line |
| pr_valid | output | 1 | Probe response valid |
| pr_ready | input | 1 | Probe response taken |

## Verification
A corrupted table entry shows up on the lookup port one cycle after the response, probe or eviction that wrote it. It also shows later, as a wrong write command kind when that line is evicted. A lost in-flight flag lets a duplicate read command through on the cycle after the second request. A lost acknowledge shows as a missing `ra_valid` one cycle after the response, and it leaves the line blocked from then on. A miscounted write total shows as `pc_ready` or `ev_ready` at the wrong level in the cycle after the write response arrives.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef struct packed {
        logic valid;
        logic uniq;
        logic owner;
        logic dirty;
    } line_st_t;

    typedef enum logic [1:0] {
        OP_SHARED = 2'd0,
        OP_UNIQUE = 2'd1,
        OP_ONCE   = 2'd2,
        OP_MKUNQ  = 2'd3
    } rd_op_e;

    typedef enum logic [1:0] {
        RSP_OK   = 2'd0,
        RSP_ERR  = 2'd1,
        RSP_DATA = 2'd2
    } rsp_kind_e;

    typedef enum logic {
        PRB_SHARE = 1'b0,
        PRB_INVAL = 1'b1
    } prb_kind_e;

endpackage

// File: rtl/coh_line_table.sv
module coh_line_table
    import coh_pkg::*;
#(
    parameter int LINES = 8,
    localparam int AW = $clog2(LINES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rsp_en,
    input  logic [AW-1:0]            rsp_addr,
    input  line_st_t                 rsp_val,
    input  logic                     prb_en,
    input  logic [AW-1:0]            prb_addr,
    input  line_st_t                 prb_val,
    input  logic                     evc_en,
    input  logic [AW-1:0]            evc_addr,
    output line_st_t [LINES-1:0]     lines_o
);

    line_st_t [LINES-1:0] lines_d, lines_q;

    // Same-cycle writes: eviction wins over probe, probe over response.
    always_comb begin
        lines_d = lines_q;
        if (rsp_en) lines_d[rsp_addr] = rsp_val;
        if (prb_en) lines_d[prb_addr] = prb_val;
        if (evc_en) lines_d[evc_addr] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lines_q <= '0;
        else        lines_q <= lines_d;
    end

    assign lines_o = lines_q;

    for (genvar g = 0; g < LINES; g++) begin : g_inv
        a_r11_dirty_owner: assert property (@(posedge clk) disable iff (!rst_n)
            lines_q[g].dirty |-> lines_q[g].owner);
    end

endmodule

// File: rtl/coh_wr_tracker.sv
module coh_wr_tracker #(
    parameter int MAX_WR = 4,
    localparam int CW = $clog2(MAX_WR + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic room_o,
    output logic idle_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && !dec)      cnt_d = cnt_q + CW'(1);
        else if (dec && !inc) cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign room_o = (cnt_q < CW'(MAX_WR));
    assign idle_o = (cnt_q == '0);

    a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> cnt_q != '0);
    a_r9_cap: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAX_WR));

endmodule

// File: rtl/coh_master_port.sv
module coh_master_port
    import coh_pkg::*;
#(
    parameter int LINES  = 8,
    parameter int MAX_WR = 4,
    localparam int AW = $clog2(LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic          ev_valid,
    output logic          ev_ready,
    input  logic [AW-1:0] ev_addr,
    input  logic [AW-1:0] lk_addr,
    output logic [3:0]    lk_state,
    output logic          rc_valid,
    input  logic          rc_ready,
    output logic [1:0]    rc_op,
    output logic [AW-1:0] rc_addr,
    input  logic          rr_valid,
    output logic          rr_ready,
    input  logic [1:0]    rr_kind,
    input  logic [AW-1:0] rr_addr,
    input  logic [3:0]    rr_state,
    output logic          ra_valid,
    input  logic          ra_ready,
    output logic [AW-1:0] ra_addr,
    output logic          wc_valid,
    input  logic          wc_ready,
    output logic          wc_kind,
    output logic [AW-1:0] wc_addr,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic          pc_valid,
    output logic          pc_ready,
    input  logic          pc_kind,
    input  logic [AW-1:0] pc_addr,
    output logic          pr_valid,
    input  logic          pr_ready
);

    typedef struct packed {
        logic                  rc_valid;
        logic [1:0]            rc_op;
        logic [AW-1:0]         rc_addr;
        logic                  ra_valid;
        logic [AW-1:0]         ra_addr;
        logic                  wc_valid;
        logic                  wc_kind;
        logic [AW-1:0]         wc_addr;
        logic                  pr_valid;
        logic [LINES-1:0]      pend;
        logic [LINES-1:0][1:0] pend_op;
    } port_st_t;

    port_st_t d, q;
    line_st_t [LINES-1:0] lines;
    line_st_t rsp_in, rsp_old, rsp_new, prb_old, prb_new, ev_old;
    logic rc_free, ra_free, wc_free, pr_free;
    logic req_fire, rr_fire, ev_fire, ev_emit, pc_fire;
    logic wr_room, wr_idle;

    // Stream slot availability: each output slot frees when taken.
    assign rc_free  = !q.rc_valid || rc_ready;
    assign ra_free  = !q.ra_valid || ra_ready;
    assign wc_free  = !q.wc_valid || wc_ready;
    assign pr_free  = !q.pr_valid || pr_ready;

    assign req_ready = rc_free && !q.pend[req_addr];
    assign rr_ready  = ra_free;
    assign ev_ready  = wc_free && wr_room;
    assign pc_ready  = pr_free && wr_idle;
    assign wr_ready  = 1'b1;

    assign req_fire = req_valid && req_ready;
    assign rr_fire  = rr_valid && rr_ready;
    assign ev_fire  = ev_valid && ev_ready;
    assign pc_fire  = pc_valid && pc_ready;

    assign rsp_in  = line_st_t'(rr_state);
    assign rsp_old = lines[rr_addr];
    assign prb_old = lines[pc_addr];
    assign ev_old  = lines[ev_addr];
    assign ev_emit = ev_fire && ev_old.valid;

    // New line state from a read response.
    always_comb begin
        rsp_new = rsp_old;
        case (rr_kind)
            RSP_ERR:  rsp_new = '0;
            RSP_DATA: if (q.pend_op[rr_addr] != OP_ONCE) rsp_new = rsp_in;
            default: begin
                rsp_new.valid = 1'b1;
                rsp_new.uniq  = 1'b1;
            end
        endcase
    end

    // New line state from a probe.
    always_comb begin
        prb_new = prb_old;
        if (pc_kind == PRB_INVAL) prb_new = '0;
        else                      prb_new.uniq = 1'b0;
    end

    always_comb begin
        d = q;
        // read command
        if (q.rc_valid && rc_ready) d.rc_valid = 1'b0;
        if (req_fire) begin
            d.rc_valid          = 1'b1;
            d.rc_op             = req_op;
            d.rc_addr           = req_addr;
            d.pend[req_addr]    = 1'b1;
            d.pend_op[req_addr] = req_op;
        end
        // read acknowledge ends the in-flight window of its line
        if (q.ra_valid && ra_ready) begin
            d.ra_valid          = 1'b0;
            d.pend[q.ra_addr]   = 1'b0;
        end
        if (rr_fire) begin
            d.ra_valid = 1'b1;
            d.ra_addr  = rr_addr;
        end
        // write command
        if (q.wc_valid && wc_ready) d.wc_valid = 1'b0;
        if (ev_emit) begin
            d.wc_valid = 1'b1;
            d.wc_kind  = ev_old.dirty;
            d.wc_addr  = ev_addr;
        end
        // probe response
        if (q.pr_valid && pr_ready) d.pr_valid = 1'b0;
        if (pc_fire) d.pr_valid = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    coh_line_table #(.LINES(LINES)) table_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rsp_en   (rr_fire),
        .rsp_addr (rr_addr),
        .rsp_val  (rsp_new),
        .prb_en   (pc_fire),
        .prb_addr (pc_addr),
        .prb_val  (prb_new),
        .evc_en   (ev_emit),
        .evc_addr (ev_addr),
        .lines_o  (lines)
    );

    coh_wr_tracker #(.MAX_WR(MAX_WR)) wtrk_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (ev_emit),
        .dec    (wr_valid),
        .room_o (wr_room),
        .idle_o (wr_idle)
    );

    assign lk_state = lines[lk_addr];
    assign rc_valid = q.rc_valid;
    assign rc_op    = q.rc_op;
    assign rc_addr  = q.rc_addr;
    assign ra_valid = q.ra_valid;
    assign ra_addr  = q.ra_addr;
    assign wc_valid = q.wc_valid;
    assign wc_kind  = q.wc_kind;
    assign wc_addr  = q.wc_addr;
    assign pr_valid = q.pr_valid;

    a_r2_rc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rc_valid && !rc_ready |=> rc_valid && $stable(rc_addr) && $stable(rc_op));
    a_r3_pend_on_issue: assert property (@(posedge clk) disable iff (!rst_n)
        rc_valid |-> q.pend[rc_addr]);
    a_r4_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ra_valid && !ra_ready |=> ra_valid && $stable(ra_addr));
    a_r4_rsp_free: assert property (@(posedge clk) disable iff (!rst_n)
        !ra_valid |-> rr_ready);
    a_r8_wc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wc_valid && !wc_ready |=> wc_valid && $stable(wc_addr) && $stable(wc_kind));
    a_r10_pr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        pr_valid && !pr_ready |=> pr_valid);

endmodule

// File: tb/coh_master_port_tb_top.sv
`timescale 1ns/1ps
module coh_master_port_tb_top;

    localparam int LINES  = 8;
    localparam int MAX_WR = 4;
    localparam int AW     = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic req_valid = 0, rc_ready = 1, rr_valid = 0, ra_ready = 1;
    logic ev_valid = 0, wc_ready = 1, wr_valid = 0, pc_valid = 0, pr_ready = 1;
    logic [1:0] req_op = 0, rr_kind = 0;
    logic [AW-1:0] req_addr = 0, ev_addr = 0, lk_addr = 0, rr_addr = 0, pc_addr = 0;
    logic [3:0] rr_state = 0;
    logic pc_kind = 0;
    logic req_ready, ev_ready, rc_valid, rr_ready, ra_valid, wc_valid, wc_kind;
    logic wr_ready, pc_ready, pr_valid;
    logic [1:0] rc_op;
    logic [AW-1:0] rc_addr, ra_addr, wc_addr;
    logic [3:0] lk_state;

    coh_master_port #(.LINES(LINES), .MAX_WR(MAX_WR)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_addr(ev_addr),
        .lk_addr(lk_addr), .lk_state(lk_state),
        .rc_valid(rc_valid), .rc_ready(rc_ready), .rc_op(rc_op), .rc_addr(rc_addr),
        .rr_valid(rr_valid), .rr_ready(rr_ready), .rr_kind(rr_kind), .rr_addr(rr_addr),
        .rr_state(rr_state),
        .ra_valid(ra_valid), .ra_ready(ra_ready), .ra_addr(ra_addr),
        .wc_valid(wc_valid), .wc_ready(wc_ready), .wc_kind(wc_kind), .wc_addr(wc_addr),
        .wr_valid(wr_valid), .wr_ready(wr_ready),
        .pc_valid(pc_valid), .pc_ready(pc_ready), .pc_kind(pc_kind), .pc_addr(pc_addr),
        .pr_valid(pr_valid), .pr_ready(pr_ready)
    );

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    logic [3:0] exp_st [LINES];

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL R1 watchdog: act cycles %0d exp below 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act %0h exp %0h", tag, act, exp);
        end
    endtask

    // Expected line state after a read response (R5, R6, R7).
    function automatic logic [3:0] rsp_model(input logic [1:0] op, input logic [1:0] kind,
                                             input logic [3:0] st, input logic [3:0] old);
        if (kind == 2'd1) return 4'b0000;
        if (kind == 2'd2) return (op == 2'd2) ? old : st;
        return old | 4'b1100;
    endfunction

    function automatic logic [3:0] pick_state(input logic [1:0] op, input int r);
        logic [3:0] shr [3] = '{4'b1000, 4'b1010, 4'b1011};
        logic [3:0] unq [3] = '{4'b1100, 4'b1110, 4'b1111};
        if (op == 2'd0) return shr[r % 3];
        if (op == 2'd1) return unq[r % 3];
        return ((r % 2) == 0) ? shr[r % 3] : unq[r % 3];
    endfunction

    task automatic chk_line(input logic [AW-1:0] a, input string tag);
        lk_addr = a;
        #0.5;
        check(lk_state == exp_st[a], tag, lk_state, exp_st[a]);
    endtask

    task automatic send_req(input logic [1:0] op, input logic [AW-1:0] a);
        @(negedge clk);
        req_valid = 1; req_op = op; req_addr = a;
        #0.5;
        while (!req_ready) begin @(negedge clk); #0.5; end
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        check(rc_valid && rc_op == op && rc_addr == a, "R2 read command",
              {rc_valid, rc_op, 1'b0, rc_addr}, {1'b1, op, 1'b0, a});
    endtask

    task automatic send_rsp(input logic [1:0] op, input logic [1:0] kind,
                            input logic [AW-1:0] a, input logic [3:0] st);
        @(negedge clk);
        rr_valid = 1; rr_kind = kind; rr_addr = a; rr_state = st;
        #0.5;
        while (!rr_ready) begin @(negedge clk); #0.5; end
        @(posedge clk);
        @(negedge clk);
        rr_valid = 0;
        check(ra_valid && ra_addr == a, "R4 read ack", {ra_valid, 1'b0, ra_addr}, {1'b1, 1'b0, a});
        exp_st[a] = rsp_model(op, kind, st, exp_st[a]);
        chk_line(a, kind == 2'd1 ? "R6 error state" : (kind == 2'd0 ? "R7 upgrade state" : "R5 data state"));
    endtask

    task automatic evict(input logic [AW-1:0] a, input logic respond);
        logic was_valid;
        was_valid = exp_st[a][3];
        @(negedge clk);
        ev_valid = 1; ev_addr = a;
        #0.5;
        while (!ev_ready) begin @(negedge clk); #0.5; end
        @(posedge clk);
        @(negedge clk);
        ev_valid = 0;
        if (was_valid)
            check(wc_valid && wc_kind == exp_st[a][0] && wc_addr == a, "R8 write command",
                  {wc_valid, wc_kind, 1'b0, wc_addr}, {1'b1, exp_st[a][0], 1'b0, a});
        else
            check(!wc_valid, "R8 no write for invalid line", wc_valid, 0);
        exp_st[a] = 4'b0000;
        chk_line(a, "R8 evicted state");
        if (was_valid && respond) begin
            @(negedge clk); wr_valid = 1;
            @(negedge clk); wr_valid = 0;
        end
    endtask

    task automatic probe(input logic kind, input logic [AW-1:0] a);
        @(negedge clk);
        pc_valid = 1; pc_kind = kind; pc_addr = a;
        #0.5;
        while (!pc_ready) begin @(negedge clk); #0.5; end
        @(posedge clk);
        @(negedge clk);
        pc_valid = 0;
        check(pr_valid, "R10 probe response", pr_valid, 1);
        exp_st[a] = kind ? 4'b0000 : (exp_st[a] & 4'b1011);
        chk_line(a, "R10 probed state");
    endtask

    task automatic fill(input logic [1:0] op, input logic [1:0] kind,
                        input logic [AW-1:0] a, input logic [3:0] st);
        send_req(op, a);
        send_rsp(op, kind, a, st);
    endtask

    initial begin
        void'($urandom(32'h5EED_C0DE));
        for (int i = 0; i < LINES; i++) exp_st[i] = 4'b0000;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < LINES; i++) chk_line(AW'(i), "R1 reset line");
        check(!rc_valid && !ra_valid && !wc_valid && !pr_valid, "R1 outputs idle",
              {rc_valid, ra_valid, wc_valid, pr_valid}, 0);
        check(req_ready, "R1 req_ready", req_ready, 1);

        // R5/R6/R7 directed
        fill(2'd0, 2'd2, 3'd1, 4'b1010);
        fill(2'd1, 2'd2, 3'd2, 4'b1111);
        fill(2'd2, 2'd2, 3'd3, 4'b1100);   // read-once: line 3 stays invalid
        fill(2'd0, 2'd1, 3'd4, 4'b1000);   // error
        fill(2'd3, 2'd0, 3'd1, 4'b0000);   // make-unique on a shared owner line

        // R3 same-line stall, R4 ack back-pressure
        send_req(2'd0, 3'd5);
        @(negedge clk);
        req_valid = 1; req_op = 2'd1; req_addr = 3'd5;
        #0.5;
        check(!req_ready, "R3 same line stalled", req_ready, 0);
        req_addr = 3'd6;
        #0.5;
        check(req_ready, "R3 other line accepted", req_ready, 1);
        req_valid = 0;
        ra_ready = 0;
        @(negedge clk);
        rr_valid = 1; rr_kind = 2'd2; rr_addr = 3'd5; rr_state = 4'b1000;
        @(negedge clk);
        rr_valid = 0;
        exp_st[5] = 4'b1000;
        req_valid = 1; req_addr = 3'd5;
        #0.5;
        check(ra_valid && ra_addr == 3'd5, "R4 ack pending", {ra_valid, ra_addr}, {1'b1, 3'd5});
        check(!rr_ready, "R4 response held while ack waits", rr_ready, 0);
        check(!req_ready, "R3 stall until ack sent", req_ready, 0);
        req_valid = 0;
        ra_ready = 1;
        @(negedge clk);
        req_valid = 1; req_addr = 3'd5;
        #0.5;
        check(req_ready && !ra_valid, "R3 released after ack", {req_ready, ra_valid}, 2'b10);
        req_valid = 0;
        chk_line(3'd5, "R5 data state");

        // R8 eviction kinds, R9 write-outstanding interlock
        fill(2'd1, 2'd2, 3'd0, 4'b1100);
        fill(2'd1, 2'd2, 3'd3, 4'b1111);
        fill(2'd1, 2'd2, 3'd6, 4'b1110);
        fill(2'd0, 2'd2, 3'd7, 4'b1000);
        evict(3'd4, 1'b1);                 // invalid line: nothing emitted
        evict(3'd0, 1'b0);
        evict(3'd3, 1'b0);
        evict(3'd6, 1'b0);
        evict(3'd7, 1'b0);
        @(negedge clk);
        ev_valid = 1; ev_addr = 3'd2;
        pc_valid = 1; pc_kind = 1'b0; pc_addr = 3'd1;
        #0.5;
        check(!ev_ready, "R9 eviction capped", ev_ready, 0);
        check(!pc_ready, "R9 probe held by writes", pc_ready, 0);
        ev_valid = 0;
        pc_valid = 0;
        for (int k = 0; k < MAX_WR; k++) begin
            @(negedge clk); wr_valid = 1;
            #0.5;
            check(!pc_ready, "R9 probe held until last response", pc_ready, 0);
        end
        @(negedge clk); wr_valid = 0;
        #0.5;
        check(pc_ready && ev_ready, "R9 released", {pc_ready, ev_ready}, 2'b11);

        probe(1'b0, 3'd1);
        probe(1'b1, 3'd2);

        // constrained random mix
        for (int it = 0; it < 300; it++) begin
            int act;
            int r;
            logic [1:0] op;
            logic [1:0] kind;
            logic [AW-1:0] a;
            act = int'($urandom % 4);
            r = int'($urandom % 64);
            a = AW'($urandom % LINES);
            if (act <= 1) begin
                op = 2'($urandom % 4);
                if (op == 2'd3) kind = 2'd0;
                else kind = (($urandom % 5) == 0) ? 2'd1 : 2'd2;
                fill(op, kind, a, pick_state(op, r));
            end else if (act == 2) begin
                evict(a, 1'b1);
            end else begin
                probe(1'($urandom % 2), a);
            end
        end

        repeat (4) @(negedge clk);
        for (int i = 0; i < LINES; i++) chk_line(AW'(i), "R11 final table");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule